// File: doc/BRIEF.md
# Record-Path Level Guard

This block sits on the stereo record path right after decimation. Each left/right sample pair passes through it on a valid/ready stream. The block does two jobs on that stream. It raises a record-level warning flag when either channel comes close to full scale. It also forces the outgoing samples to zero while the upstream filters settle after reset, power-up or a clock restart.

The warning flag is held by a timer that counts sample transfers, not clock cycles. Every new overload restarts the timer. The length of the settling mute depends on the DC-removal filter enable. If that enable is seen high at any point during the mute, the longer length is used.

The stream has no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A sample moves only in a cycle where both `in_valid` and `out_ready` are high. Holding `out_ready` low stalls the source without losing or counting a sample. Only transfers advance the counters.

Top module: `rec_level_guard`

## Requirements
- R1: The stream is combinational. `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. A transfer happens in a cycle where `in_valid` and `out_ready` are both high. Cycles without a transfer advance no counter.
- R2: A transfer is an overload when the magnitude of either channel, read as a 20-bit two's-complement value, is strictly greater than `OVL_THRESH`. The default is 458752 (0x70000), about 1.16 dB below the largest positive code. A magnitude exactly equal to the threshold is not an overload. The most negative code (0x80000) is an overload. After an overload transfer, `over_flag` is high from the next cycle.
- R3: After the last overload, `over_flag` stays high through 511 further non-overload transfers. It goes low in the cycle after the 512th such transfer (`HOLD_SAMPLES` = 512). Idle and stalled cycles do not shorten the hold.
- R4: An overload while `over_flag` is high restarts the full 512-transfer hold from that transfer.
- R5: With `dc_filt_en` low throughout, the first 1024 transfers after the mute starts carry zero on both output channels. From the 1025th transfer on, the output equals the input.
- R6: With `dc_filt_en` high, the first 12288 transfers are zeroed and the 12289th passes unchanged.
- R7: If `dc_filt_en` is high in any cycle while the mute is active, the 12288-transfer length applies even if the enable drops again. A change of `dc_filt_en` after the mute has ended has no effect on the output.
- R8: A one-cycle `settle_restart` pulse restarts the mute count from zero. It leaves `over_flag` and the hold count untouched.
- R9: Reset (`rst_n` low) clears `over_flag` and the hold count, and restarts the mute.
- R10: Overload detection also works on transfers that are being muted. A muted overload transfer outputs zero and still raises `over_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_restart | input | 1 | Pulse after power-up recovery or clock start; restarts the mute |
| dc_filt_en | input | 1 | DC-removal filter enabled upstream; selects the long mute |
| in_valid | input | 1 | Sample pair present on the input |
| in_ready | output | 1 | Input may transfer (equals out_ready) |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| out_valid | output | 1 | Sample pair present on the output (equals in_valid) |
| out_ready | input | 1 | Downstream accepts the pair |
| out_left | output | 20 | Left sample, zeroed while muted |
| out_right | output | 20 | Right sample, zeroed while muted |
| over_flag | output | 1 | Record-level overload warning |

## Verification
Overload detection and the settling mute can act on the same transfer. An overload sample arriving while the output is still zeroed must leave the output at zero and still raise the flag. The bench provokes this in two places: on the very first transfer after reset, and on the 1024th transfer, the last muted one. In both cases it checks the zeroed output during the transfer and the raised flag one cycle later. It also checks that the next clean transfer passes through unchanged, which shows that the last mute transfer and the hold-timer load did not disturb each other.

// File: rtl/rlg_pkg.sv
`timescale 1ns/1ps
package rlg_pkg;
  localparam int CHANS = 2;

  typedef enum logic {
    GATE_MUTE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;
endpackage

// File: rtl/rlg_mag_cmp.sv
`timescale 1ns/1ps
// Magnitude compare of one two's-complement sample against a positive limit.
module rlg_mag_cmp #(
  parameter int W   = 20,
  parameter int THR = 458752
) (
  input  logic [W-1:0] smp,
  output logic         over
);
  localparam logic [W-1:0] THR_U = W'(THR);

  logic [W-1:0] mag;

  // The negation of the most negative code wraps to 2^(W-1), which is
  // larger than any legal limit, so that code always counts as over.
  always_comb begin
    mag  = smp[W-1] ? (~smp + 1'b1) : smp;
    over = (mag > THR_U);
  end
endmodule

// File: rtl/rlg_hold_timer.sv
`timescale 1ns/1ps
// Retriggerable hold window counted in sample transfers.
module rlg_hold_timer #(
  parameter int HOLD = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic hit,
  output logic flag
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step && hit) begin
      cnt <= CW'(HOLD);
    end else if (step && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign flag = (cnt != '0);
endmodule

// File: rtl/rlg_settle_gate.sv
`timescale 1ns/1ps
// Startup mute: zero the output for a number of transfers chosen by the
// DC-filter enable; the long length sticks once the enable is seen.
module rlg_settle_gate
  import rlg_pkg::*;
#(
  parameter int SHORT_LEN = 1024,
  parameter int LONG_LEN  = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic dc_en,
  input  logic step,
  output logic open
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_LEN);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_LEN);

  gate_e         state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  logic          dc_seen;
  logic [CW-1:0] limit;

  always_comb begin
    nxt   = cnt + 1'b1;
    limit = (dc_seen || dc_en) ? LONG_C : SHORT_C;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      state   <= GATE_MUTE;
      cnt     <= '0;
      dc_seen <= 1'b0;
    end else if (state == GATE_MUTE) begin
      dc_seen <= dc_seen | dc_en;
      if (step) begin
        cnt <= nxt;
        if (nxt >= limit) begin
          state <= GATE_OPEN;
        end
      end
    end
  end

  assign open = (state == GATE_OPEN);
endmodule

// File: rtl/rec_level_guard.sv
`timescale 1ns/1ps
// Record-path level guard: overload flag with retriggerable hold and
// startup mute on a pass-through valid/ready sample stream.
module rec_level_guard
  import rlg_pkg::*;
#(
  parameter int SAMPLE_W     = 20,
  parameter int OVL_THRESH   = 458752,
  parameter int HOLD_SAMPLES = 512,
  parameter int MUTE_SHORT   = 1024,
  parameter int MUTE_LONG    = 12288
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                settle_restart,
  input  logic                dc_filt_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                over_flag
);
  logic [SAMPLE_W-1:0] ch_in  [CHANS];
  logic [SAMPLE_W-1:0] ch_out [CHANS];
  logic [CHANS-1:0]    ch_over;
  logic                xfer;
  logic                gate_open;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign xfer      = in_valid && out_ready;

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    rlg_mag_cmp #(
      .W   (SAMPLE_W),
      .THR (OVL_THRESH)
    ) u_cmp (
      .smp  (ch_in[c]),
      .over (ch_over[c])
    );
    assign ch_out[c] = gate_open ? ch_in[c] : '0;
  end

  rlg_hold_timer #(
    .HOLD (HOLD_SAMPLES)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (xfer),
    .hit   (|ch_over),
    .flag  (over_flag)
  );

  rlg_settle_gate #(
    .SHORT_LEN (MUTE_SHORT),
    .LONG_LEN  (MUTE_LONG)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (settle_restart),
    .dc_en   (dc_filt_en),
    .step    (xfer),
    .open    (gate_open)
  );
endmodule

// File: rtl/rlg_checker.sv
`timescale 1ns/1ps
module rlg_checker #(
  parameter int SAMPLE_W     = 20,
  parameter int OVL_THRESH   = 458752,
  parameter int MUTE_SHORT   = 1024,
  parameter int MUTE_LONG    = 12288
) (
  input logic                clk,
  input logic                rst_n,
  input logic                settle_restart,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SAMPLE_W-1:0] in_left,
  input logic [SAMPLE_W-1:0] in_right,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                over_flag
);
  localparam int CW = $clog2(MUTE_LONG + 1);
  localparam logic signed [SAMPLE_W:0] TP = (SAMPLE_W+1)'(OVL_THRESH);

  logic                     xfer;
  logic signed [SAMPLE_W:0] sl;
  logic signed [SAMPLE_W:0] sr;
  logic                     big;
  logic [CW-1:0]            seen;

  assign xfer = in_valid && out_ready;
  assign sl   = {in_left[SAMPLE_W-1], in_left};
  assign sr   = {in_right[SAMPLE_W-1], in_right};
  assign big  = (sl > TP) || (sl < -TP) || (sr > TP) || (sr < -TP);

  // Transfers since the mute last started, saturating at the long length.
  always_ff @(posedge clk) begin
    if (!rst_n || settle_restart) seen <= '0;
    else if (xfer && (seen < CW'(MUTE_LONG))) seen <= seen + 1'b1;
  end

  p_stream_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == out_ready) && (out_valid == in_valid));

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && big) |=> over_flag);

  p_hold_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(over_flag));

  p_mute_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (seen < CW'(MUTE_SHORT))) |-> (out_left == '0 && out_right == '0));

  p_open_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (seen >= CW'(MUTE_LONG))) |-> (out_left == in_left && out_right == in_right));
endmodule

bind rec_level_guard rlg_checker #(
  .SAMPLE_W   (SAMPLE_W),
  .OVL_THRESH (OVL_THRESH),
  .MUTE_SHORT (MUTE_SHORT),
  .MUTE_LONG  (MUTE_LONG)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .settle_restart (settle_restart),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_left        (in_left),
  .in_right       (in_right),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_left       (out_left),
  .out_right      (out_right),
  .over_flag      (over_flag)
);

// File: tb/sim_rec_level_guard.sv
`timescale 1ns/1ps
module sim_rec_level_guard;
  localparam int W = 20;
  localparam logic [W-1:0] THR_P  = 20'h70000;
  localparam logic [W-1:0] THR_N  = 20'h90000;
  localparam logic [W-1:0] OVR_P  = 20'h70001;
  localparam logic [W-1:0] OVR_N  = 20'h8FFFF;
  localparam logic [W-1:0] MNEG   = 20'h80000;
  localparam logic [W-1:0] CLN_L  = 20'h03039;
  localparam logic [W-1:0] CLN_R  = 20'hFFFF9;

  logic clk = 1'b0;
  logic rst_n, restart, dc_en, in_valid, out_ready;
  logic [W-1:0] il, ir;
  logic in_ready, out_valid, flag;
  logic [W-1:0] ol, orr;
  logic [W-1:0] got_l, got_r;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rec_level_guard u0 (
    .clk(clk), .rst_n(rst_n), .settle_restart(restart), .dc_filt_en(dc_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(il), .in_right(ir),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(ol), .out_right(orr),
    .over_flag(flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1; il = l; ir = r;
    #1;
    got_l = ol; got_r = orr;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic send_clean(input int n, output int nz);
    nz = 0;
    for (int i = 0; i < n; i++) begin
      send(CLN_L, CLN_R);
      if (got_l != '0 || got_r != '0) nz++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_pass(input string req);
    send(CLN_L, CLN_R);
    chk(got_l == CLN_L && got_r == CLN_R, req, "sample passes after mute", got_l, CLN_L);
  endtask

  task automatic t_reset();
    int nz;
    do_reset();
    #1;
    chk(flag == 1'b0, "R9", "flag after reset", flag, 0);
    // stall with overload data: no transfer, no effect
    in_valid = 1'b1; out_ready = 1'b0; il = MNEG; ir = MNEG;
    repeat (5) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R1", "in_ready follows out_ready low", in_ready, 0);
    chk(out_valid == 1'b1, "R1", "out_valid follows in_valid", out_valid, 1);
    chk(flag == 1'b0, "R1", "stalled overload ignored", flag, 0);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "ready high, valid low", in_ready, 1);
  endtask

  task automatic t_short();
    int nz;
    do_reset();
    dc_en = 1'b0;
    // stalled cycles do not count toward the mute
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b0; il = CLN_L; ir = CLN_R;
    repeat (6) @(negedge clk);
    send_clean(1024, nz);
    chk(nz == 0, "R5", "nonzero outputs in short mute", nz, 0);
    check_pass("R5");
    // enable changes after the mute has ended have no effect
    idle(); dc_en = 1'b1;
    check_pass("R7");
    idle(); dc_en = 1'b0;
  endtask

  task automatic t_thresh();
    do_reset(); send(THR_P, THR_P); idle();
    chk(flag == 1'b0, "R2", "magnitude equal to +limit", flag, 0);
    do_reset(); send(THR_N, THR_N); idle();
    chk(flag == 1'b0, "R2", "magnitude equal to -limit", flag, 0);
    do_reset(); send(CLN_L, OVR_P); idle();
    chk(flag == 1'b1, "R2", "right channel +limit+1", flag, 1);
    do_reset(); send(OVR_N, CLN_R); idle();
    chk(flag == 1'b1, "R2", "left channel -(limit+1)", flag, 1);
    do_reset(); send(MNEG, CLN_R); idle();
    chk(flag == 1'b1, "R2", "most negative code", flag, 1);
  endtask

  task automatic t_hold();
    int nz;
    do_reset();
    send(OVR_P, CLN_R); idle();
    chk(flag == 1'b1, "R3", "flag after overload", flag, 1);
    repeat (20) @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0; il = CLN_L; ir = CLN_R;
    repeat (10) @(negedge clk);
    idle();
    chk(flag == 1'b1, "R3", "idle and stall keep flag", flag, 1);
    send_clean(511, nz); idle();
    chk(flag == 1'b1, "R3", "flag after 511 clean", flag, 1);
    send_clean(1, nz); idle();
    chk(flag == 1'b0, "R3", "flag after 512 clean", flag, 0);
  endtask

  task automatic t_retrig();
    int nz;
    do_reset();
    send(CLN_L, OVR_N);
    send_clean(300, nz);
    send(OVR_P, CLN_R);
    send_clean(511, nz); idle();
    chk(flag == 1'b1, "R4", "flag 511 after retrigger", flag, 1);
    send_clean(1, nz); idle();
    chk(flag == 1'b0, "R4", "flag 512 after retrigger", flag, 0);
  endtask

  task automatic t_long();
    int nz;
    dc_en = 1'b1;
    do_reset();
    send_clean(12288, nz);
    chk(nz == 0, "R6", "nonzero outputs in long mute", nz, 0);
    check_pass("R6");
    idle(); dc_en = 1'b0;
  endtask

  task automatic t_switch();
    int nz;
    dc_en = 1'b0;
    do_reset();
    send_clean(500, nz);
    @(negedge clk); in_valid = 1'b0; dc_en = 1'b1;
    @(negedge clk); dc_en = 1'b0;
    send_clean(11788, nz);
    chk(nz == 0, "R7", "enable pulse extends mute", nz, 0);
    check_pass("R7");
    idle();
  endtask

  task automatic t_restart();
    int nz;
    dc_en = 1'b0;
    do_reset();
    send_clean(1024, nz);
    send(OVR_P, OVR_P);
    chk(got_l == OVR_P, "R8", "open before restart", got_l, OVR_P);
    @(negedge clk); in_valid = 1'b0; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    #1;
    chk(flag == 1'b1, "R8", "flag kept over restart", flag, 1);
    send_clean(1024, nz);
    chk(nz == 0, "R8", "mute after restart", nz, 0);
    check_pass("R8");
    idle();
  endtask

  task automatic t_concurrent();
    int nz;
    dc_en = 1'b0;
    do_reset();
    send(MNEG, CLN_R);
    chk(got_l == '0 && got_r == '0, "R10", "first muted overload zeroed", got_l, 0);
    idle();
    chk(flag == 1'b1, "R10", "flag from muted overload", flag, 1);
    do_reset();
    send_clean(1023, nz);
    send(OVR_P, OVR_N);
    chk(got_l == '0 && got_r == '0, "R10", "last muted overload zeroed", got_l, 0);
    idle();
    chk(flag == 1'b1, "R10", "flag from last muted transfer", flag, 1);
    check_pass("R10");
    idle();
  endtask

  task automatic t_reset_mid();
    int nz;
    do_reset();
    send_clean(1024, nz);
    send(OVR_P, CLN_R); idle();
    do_reset();
    #1;
    chk(flag == 1'b0, "R9", "reset clears held flag", flag, 0);
    send(OVR_P, OVR_P);
    chk(got_l == '0, "R9", "reset restarts mute", got_l, 0);
    send_clean(512, nz); idle();
    chk(flag == 1'b0, "R9", "hold count restarted by reset", flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; dc_en = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0; il = '0; ir = '0;
    t_reset();
    t_short();
    t_thresh();
    t_hold();
    t_retrig();
    t_long();
    t_switch();
    t_restart();
    t_concurrent();
    t_reset_mid();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule